// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Controller

This block is the digital core of a processor supervisor. It receives a supply-good flag from an external threshold comparator. It also receives a watchdog activity input with a separate "input is floating" qualifier, a timebase tick, and a timeout-mode select. From these it produces an active-low reset, the matching active-high reset, a watchdog-fault flag and a low-supply flag.

When the supply drops, reset asserts at once. Reset is held for a fixed number of ticks after the supply recovers. After reset ends, the processor must toggle the watchdog input within a window.

- The first window after any reset is the long one.
- Later windows are long or short, as the mode select decides.

If the window expires, the fault flag drops and a reset pulse is issued. The fault flag stays low until the watchdog input moves again. A watchdog input that never moves therefore produces a reset pulse once every hold-off plus long window. A floating watchdog input switches the watchdog off.

All durations are parameters counted in ticks. The defaults are:

| Duration | Default |
|---|---|
| Reset hold-off | 2048 ticks |
| Short window | 1024 ticks |
| Long window | 4096 ticks |

Top module: `supvWatchdog`

## Requirements
- R1: While the synchronized supply-good flag is low, `resetN` is 0 and `resetP` is 1. An input drop becomes visible on the outputs two clocks after it is sampled.
- R2: After supply-good returns high, reset stays asserted until RST_TICKS ticks have been counted. It then deasserts.
- R3: The window that starts when reset deasserts lasts WD_LONG_TICKS ticks in both modes. If it expires, `wdoN` goes to 0 and reset asserts for RST_TICKS ticks.
- R4: Once `wdoN` has gone low, it stays low through and after the reset pulse. It returns to 1 within three clocks of the next level change on `wdiLevel`.
- R5: If `wdiLevel` never changes, reset pulses repeat. Each pulse lasts RST_TICKS ticks, and pulses start WD_LONG_TICKS ticks after the previous release.
- R6: While `wdiFloat` is 1 or supply-good is low, the watchdog is disabled, no watchdog reset occurs, and `wdoN` is 1.
- R7: `lowSupply` is the inverse of the synchronized supply-good flag, with no hold-off. It falls while reset is still held.
- R8: `resetP` is always the inverse of `resetN`.
- R9: After the first `wdiLevel` change following a reset, the window length depends on `modeShort`. With `modeShort` = 0 it is WD_LONG_TICKS ticks; with `modeShort` = 1 it is WD_NORM_TICKS ticks.
- R10: A rising or falling edge on `wdiLevel` restarts the window. A one-clock pulse of either polarity restarts it too, counting from the pulse's trailing edge.
- R11: The hold-off and window counters advance only on clocks where `tick` is 1.
- R12: While `rstN` is 0, `resetN` is 0, `resetP` is 1, `wdoN` is 1 and `lowSupply` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low initialization |
| supplyOk | input | 1 | Supply-good flag from the threshold comparator |
| wdiLevel | input | 1 | Watchdog activity input |
| wdiFloat | input | 1 | 1 when the watchdog input is left floating |
| tick | input | 1 | Timebase enable, one clock wide |
| modeShort | input | 1 | 1 selects the short normal window |
| resetN | output | 1 | Active-low processor reset |
| resetP | output | 1 | Active-high processor reset |
| wdoN | output | 1 | Watchdog fault flag, active low |
| lowSupply | output | 1 | 1 while the supply is below threshold |

## Verification
The properties check on every cycle the behaviours that follow from one or two clocks of history:

- reset and the low-supply flag track a supply drop;
- the fault flag is sticky while the input is quiet;
- the fault flag is held high while the watchdog is disabled;
- a fault always coincides with reset;
- reset is released only on a tick.

The lengths of the hold-off, the long and short windows, the periodic pulse train, restart by a one-clock pulse, and the slowed timebase span many cycles. Only the bench's scenarios show these. The bench sweeps both modes and both held levels and compares each edge against cycle counts it derives from the parameters.

// File: rtl/supvPkg.sv
package supvPkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic rstClr;   // clear hold-off counter
    logic rstInc;   // advance hold-off counter
    logic wdClr;    // clear watchdog window counter
    logic wdInc;    // advance watchdog window counter
    logic useLong;  // compare against the long window
  } supvStrobeT;

  // Conditions from datapath to control
  typedef struct packed {
    logic supOk;    // synchronized supply-good
    logic floatIn;  // synchronized floating qualifier
    logic wdiEdge;  // level change seen on the activity input
    logic rstDone;  // hold-off reaches its last tick
    logic wdExpire; // window reaches its last tick
  } supvStatusT;

endpackage

// File: rtl/supvSync.sv
module supvSync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage <= {STAGES{RST_VAL}};
    else       stage <= {stage[STAGES-2:0], d};
  end

  assign q = stage[STAGES-1];

endmodule

// File: rtl/supvDatapath.sv
module supvDatapath
  import supvPkg::*;
#(
  parameter int RST_TICKS = 2048,
  parameter int WD_NORM_TICKS = 1024,
  parameter int WD_LONG_TICKS = 4096,
  parameter int SYNC_STAGES = 2,
  localparam int RST_W = $clog2(RST_TICKS),
  localparam int WD_W = $clog2(WD_LONG_TICKS)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyOk,
  input  logic       wdiLevel,
  input  logic       wdiFloat,
  input  supvStrobeT strobe,
  output supvStatusT status
);

  // Synchronized bundle: {floating, supply-good, level}
  logic [2:0] syncQ;
  logic       wdiPrev;
  logic [RST_W-1:0] rstCnt;
  logic [WD_W-1:0]  wdCnt;
  logic [WD_W-1:0]  wdLimit;

  supvSync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk (clk),
    .rstN(rstN),
    .d   ({wdiFloat, supplyOk, wdiLevel}),
    .q   (syncQ)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wdiPrev <= 1'b0;
    else       wdiPrev <= syncQ[0];
  end

  // Reset hold-off counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rstCnt <= '0;
    else if (strobe.rstClr) rstCnt <= '0;
    else if (strobe.rstInc) rstCnt <= rstCnt + 1'b1;
  end

  // Watchdog window counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             wdCnt <= '0;
    else if (strobe.wdClr) wdCnt <= '0;
    else if (strobe.wdInc) wdCnt <= wdCnt + 1'b1;
  end

  assign wdLimit = strobe.useLong ? WD_W'(WD_LONG_TICKS - 1) : WD_W'(WD_NORM_TICKS - 1);

  assign status.supOk    = syncQ[1];
  assign status.floatIn  = syncQ[2];
  assign status.wdiEdge  = syncQ[0] ^ wdiPrev;
  assign status.rstDone  = (rstCnt == RST_W'(RST_TICKS - 1));
  assign status.wdExpire = (wdCnt >= wdLimit);

endmodule

// File: rtl/supvCtrl.sv
module supvCtrl
  import supvPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       modeShort,
  input  supvStatusT status,
  output supvStrobeT strobe,
  output logic       resetN,
  output logic       resetP,
  output logic       wdoN,
  output logic       lowSupply
);

  logic rstActive;  // hold-off or watchdog pulse in progress
  logic postReset;  // long window in force until first activity
  logic wdoReg;
  logic wdArmed;    // supply good and input driven
  logic wdRun;      // window counting allowed
  logic fault;
  logic holdEnd;

  assign wdArmed = status.supOk && !status.floatIn;
  assign wdRun   = wdArmed && !rstActive;
  assign fault   = wdRun && !status.wdiEdge && tick && status.wdExpire;
  assign holdEnd = status.supOk && rstActive && tick && status.rstDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rstActive <= 1'b1;
    else if (!status.supOk) rstActive <= 1'b1;
    else if (holdEnd)       rstActive <= 1'b0;
    else if (fault)         rstActive <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           postReset <= 1'b1;
    else if (rstActive || !status.supOk) postReset <= 1'b1;
    else if (status.wdiEdge)             postReset <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               wdoReg <= 1'b1;
    else if (!wdArmed)       wdoReg <= 1'b1;
    else if (status.wdiEdge) wdoReg <= 1'b1;
    else if (fault)          wdoReg <= 1'b0;
  end

  always_comb begin
    strobe.rstClr  = !status.supOk || fault || holdEnd;
    strobe.rstInc  = status.supOk && rstActive && tick;
    strobe.wdClr   = !wdRun || status.wdiEdge || fault;
    strobe.wdInc   = wdRun && tick;
    strobe.useLong = postReset || !modeShort;
  end

  assign resetP    = rstActive || !status.supOk;
  assign resetN    = !resetP;
  assign wdoN      = wdoReg;
  assign lowSupply = !status.supOk;

endmodule

// File: rtl/supvWatchdog.sv
module supvWatchdog
  import supvPkg::*;
#(
  parameter int RST_TICKS = 2048,
  parameter int WD_NORM_TICKS = 1024,
  parameter int WD_LONG_TICKS = 4096,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic supplyOk,
  input  logic wdiLevel,
  input  logic wdiFloat,
  input  logic tick,
  input  logic modeShort,
  output logic resetN,
  output logic resetP,
  output logic wdoN,
  output logic lowSupply
);

  supvStrobeT strobe;
  supvStatusT status;
  logic supOkSync;
  logic floatSync;
  logic wdiEdge;

  supvDatapath #(
    .RST_TICKS    (RST_TICKS),
    .WD_NORM_TICKS(WD_NORM_TICKS),
    .WD_LONG_TICKS(WD_LONG_TICKS),
    .SYNC_STAGES  (SYNC_STAGES)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .supplyOk(supplyOk),
    .wdiLevel(wdiLevel),
    .wdiFloat(wdiFloat),
    .strobe  (strobe),
    .status  (status)
  );

  supvCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick),
    .modeShort(modeShort),
    .status   (status),
    .strobe   (strobe),
    .resetN   (resetN),
    .resetP   (resetP),
    .wdoN     (wdoN),
    .lowSupply(lowSupply)
  );

  assign supOkSync = status.supOk;
  assign floatSync = status.floatIn;
  assign wdiEdge   = status.wdiEdge;

endmodule

// File: rtl/supvWatchdogChk.sv
module supvWatchdogChk (
  input logic clk,
  input logic rstN,
  input logic supplyOk,
  input logic tick,
  input logic resetN,
  input logic wdoN,
  input logic lowSupply,
  input logic supOkSync,
  input logic floatSync,
  input logic wdiEdge
);

  p_supply_low_r1: assert property (@(posedge clk) disable iff (!rstN)
    !$past(supplyOk, 2) |-> !resetN)
    else $error("R1 reset not asserted after supply drop");

  p_low_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$past(supplyOk, 2) |-> lowSupply)
    else $error("R7 low-supply flag missing");

  p_fault_reset_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wdoN) |-> !resetN)
    else $error("R3 fault without reset");

  p_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!wdoN && !wdiEdge && supOkSync && !floatSync) |=> !wdoN)
    else $error("R4 fault flag cleared without activity");

  p_disabled_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!supOkSync || floatSync) |=> wdoN)
    else $error("R6 fault flag low while disabled");

  p_tick_release_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetN) |-> $past(tick))
    else $error("R11 reset released without a tick");

endmodule

bind supvWatchdog supvWatchdogChk u_supvWatchdogChk (
  .clk      (clk),
  .rstN     (rstN),
  .supplyOk (supplyOk),
  .tick     (tick),
  .resetN   (resetN),
  .wdoN     (wdoN),
  .lowSupply(lowSupply),
  .supOkSync(supOkSync),
  .floatSync(floatSync),
  .wdiEdge  (wdiEdge)
);

// File: tb/supvWatchdog_bench.sv
module supvWatchdog_bench;

  localparam int RST = 8;
  localparam int NORM = 4;
  localparam int LONG = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyOk = 1'b1;
  logic wdiLevel = 1'b0;
  logic wdiFloat = 1'b0;
  logic tick = 1'b1;
  logic modeShort = 1'b0;
  logic slowTick = 1'b0;
  logic resetN, resetP, wdoN, lowSupply;

  int nChecks = 0;
  int nErr = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  always @(negedge clk) tick <= slowTick ? ~tick : 1'b1;

  supvWatchdog #(
    .RST_TICKS    (RST),
    .WD_NORM_TICKS(NORM),
    .WD_LONG_TICKS(LONG),
    .SYNC_STAGES  (2)
  ) u_supvWatchdog (
    .clk      (clk),
    .rstN     (rstN),
    .supplyOk (supplyOk),
    .wdiLevel (wdiLevel),
    .wdiFloat (wdiFloat),
    .tick     (tick),
    .modeShort(modeShort),
    .resetN   (resetN),
    .resetP   (resetP),
    .wdoN     (wdoN),
    .lowSupply(lowSupply)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nErr++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish();
  end

  initial begin
    step(3);
    check("R12", "resetN", resetN, 1'b0);
    check("R12", "resetP", resetP, 1'b1);
    check("R12", "wdoN", wdoN, 1'b1);
    check("R12", "lowSupply", lowSupply, 1'b1);
    rstN = 1'b1;

    for (int m = 0; m < 2; m++) begin
      for (int l = 0; l < 2; l++) begin
        automatic int lim = (m == 1) ? NORM : LONG;
        modeShort = m[0];
        wdiFloat = 1'b0;
        wdiLevel = l[0];
        supplyOk = 1'b0;
        step(2);
        check("R1", "resetN after drop", resetN, 1'b0);
        check("R8", "resetP after drop", resetP, 1'b1);
        check("R7", "lowSupply after drop", lowSupply, 1'b1);
        step(2);
        check("R6", "wdoN with supply low", wdoN, 1'b1);

        supplyOk = 1'b1;
        step(2);
        check("R7", "lowSupply during hold-off", lowSupply, 1'b0);
        check("R2", "resetN early hold-off", resetN, 1'b0);
        step(RST - 1);
        check("R2", "resetN last hold cycle", resetN, 1'b0);
        step(1);
        check("R2", "resetN released", resetN, 1'b1);
        check("R8", "resetP released", resetP, 1'b0);

        // post-reset window is long in both modes
        step(LONG - 1);
        check("R3", "wdoN before long expiry", wdoN, 1'b1);
        check("R3", "resetN before long expiry", resetN, 1'b1);
        step(1);
        check("R3", "wdoN at long expiry", wdoN, 1'b0);
        check("R3", "resetN at long expiry", resetN, 1'b0);
        step(RST - 1);
        check("R3", "resetN pulse end-1", resetN, 1'b0);
        step(1);
        check("R3", "resetN pulse done", resetN, 1'b1);
        check("R4", "wdoN sticky after pulse", wdoN, 1'b0);

        // held input repeats the pulse
        step(LONG - 1);
        check("R5", "resetN before repeat", resetN, 1'b1);
        step(1);
        check("R5", "resetN repeat pulse", resetN, 1'b0);
        step(RST);
        check("R5", "resetN repeat release", resetN, 1'b1);

        // one edge clears fault; normal window by mode
        wdiLevel = ~wdiLevel;
        step(3);
        check("R4", "wdoN cleared by edge", wdoN, 1'b1);
        step(lim - 1);
        check("R9", "wdoN before normal expiry", wdoN, 1'b1);
        step(1);
        check("R9", "wdoN at normal expiry", wdoN, 1'b0);
        check("R9", "resetN at normal expiry", resetN, 1'b0);
        step(RST);

        // steady activity keeps the processor running
        for (int i = 0; i < 3 * LONG / 2; i++) begin
          wdiLevel = ~wdiLevel;
          step(2);
        end
        check("R10", "resetN with activity", resetN, 1'b1);
        check("R10", "wdoN with activity", wdoN, 1'b1);

        // one-clock pulse restarts the window from its trailing edge
        wdiLevel = ~wdiLevel;
        step(1);
        wdiLevel = ~wdiLevel;
        step(lim + 2);
        check("R10", "wdoN after pulse", wdoN, 1'b1);
        step(1);
        check("R10", "wdoN pulse expiry", wdoN, 1'b0);
        step(RST);

        // floating input disables the watchdog
        wdiFloat = 1'b1;
        step(3 * (LONG + RST));
        check("R6", "resetN while floating", resetN, 1'b1);
        check("R6", "wdoN while floating", wdoN, 1'b1);
      end
    end

    // timebase gating: ticks on every other clock
    slowTick = 1'b1;
    wdiFloat = 1'b1;
    supplyOk = 1'b0;
    step(4);
    supplyOk = 1'b1;
    step(RST + 2);
    check("R11", "resetN with half-rate ticks", resetN, 1'b0);
    step(RST + 2);
    check("R11", "resetN release with half-rate ticks", resetN, 1'b1);

    finish();
  end

endmodule